// File: doc/BRIEF.md
# Framed On-Off-Keyed Test Transmitter

This block is a digital stimulus source for bench and silicon bring-up of a wireless receiver. It draws pseudo-random payload bytes from an internal shift-register generator. Each byte goes into a fixed twelve-bit serial frame. The frame then on-off keys a carrier. The default timing gives a 4 MHz carrier when the system clock runs at 8 MHz, with forty carrier cycles per bit, which yields 100 kbps.

The frame also serves receiver alignment. A caller can request a synchronisation frame, which carries an all-zero payload. The request is held pending until the current frame ends, so a frame that is already on the line is never cut. While enable is low the line rests at the stop level and the carrier is silent. A one-cycle marker at every bit boundary lets a checker slice the stream without recovering a clock.

Top module: `ask_frame_tx`

## Requirements
- R1: While reset is high, and in every cycle after reset until enable is sampled high, `bit_out`, `carrier_out` and `bit_mark` are 0.
- R2: A frame is 12 bits sent in this order: two start bits of value 1, then the eight payload bits least significant bit first, then the parity bit, then a stop bit of value 0.
- R3: The parity bit is even parity. It equals the XOR of the eight payload bits, so the data bits and the parity bit together hold an even count of ones.
- R4: The payload of a random frame is the low byte of a 16-bit state. After reset the state is `SEED` (default 16'hACE1). It advances once per random frame loaded, with this step: shift right by one, and if the bit shifted out was 1, XOR in 16'hB400.
- R5: Every bit lasts CLKS_PER_BIT = 2*HALF_DIV*CARR_PER_BIT clocks (80 by default). `bit_mark` is 1 only in the first clock of each bit, and `bit_out` does not change inside a bit.
- R6: During a 1 bit, `carrier_out` is 1 in clock k of the bit (k counted from 0) when floor(k/HALF_DIV) is even, and 0 otherwise. This gives CARR_PER_BIT carrier periods per bit. During a 0 bit, `carrier_out` stays 0.
- R7: A one-clock pulse on `sync_req`, whether it arrives mid-frame or while idle, leaves the current frame unchanged. The next frame that starts carries payload 8'h00 with parity 0, and it does not advance the random state.
- R8: One clock after enable is sampled low, all outputs are 0 and any frame in progress is abandoned. Its payload stays consumed. One clock after enable is sampled high from idle, a new frame starts at its first start bit with `bit_mark` high.
- R9: While enable stays high, frames follow one another with no idle clock between the stop bit and the next first start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the carrier rate by default |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Transmit enable; low forces idle |
| sync_req | input | 1 | Pulse requesting an all-zero sync frame next |
| carrier_out | output | 1 | Keyed carrier |
| bit_out | output | 1 | Baseband framed bit stream |
| bit_mark | output | 1 | High in the first clock of each bit |

## Verification
The assertions assume that `enable` and `sync_req` are synchronous to `clk` and are sampled only at clock edges. They also assume that `HALF_DIV*CARR_PER_BIT` is large enough that a bit spans more than one clock, so a marker cannot repeat in consecutive cycles. The bench changes every input half a period away from the rising edge and uses the default parameters, which give an 80-clock bit. It pulses `sync_req` for exactly one clock, both inside a frame and while idle, and it drops enable partway through a bit to exercise abandonment.

// File: rtl/ask_tx_pkg.sv
package ask_tx_pkg;
  localparam int FRAME_BITS = 12;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  typedef logic [FRAME_BITS-1:0] frame_t;

  // Bit 0 goes out first: start, start, d0..d7, even parity, stop.
  function automatic frame_t make_frame(input logic [7:0] payload);
    frame_t f;
    f[0]  = 1'b1;
    f[1]  = 1'b1;
    for (int j = 0; j < 8; j++) f[2+j] = payload[j];
    f[10] = ^payload;
    f[11] = 1'b0;
    return f;
  endfunction
endpackage

// File: rtl/ask_prbs.sv
module ask_prbs #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter logic [15:0] TAPS  = 16'hB400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  output logic [7:0] byte_o
);
  logic [WIDTH-1:0] state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED[WIDTH-1:0];
    end else if (step) begin
      if (state[0]) state <= (state >> 1) ^ TAPS[WIDTH-1:0];
      else          state <= state >> 1;
    end
  end

  assign byte_o = state[7:0];
endmodule

// File: rtl/ask_frame_seq.sv
module ask_frame_seq
  import ask_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 80,
  localparam int CNT_W = $clog2(CLKS_PER_BIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             sync_req,
  input  logic [7:0]       rand_byte,
  output logic             rand_step,
  output logic             nxt_active,
  output logic             nxt_bit,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             bit_q,
  output logic             mark_q
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  frame_t           shreg;
  logic             pend;

  logic             last_clk, frame_end, load, use_sync;
  logic [IDX_W-1:0] nxt_idx;
  frame_t           nxt_shreg, new_frame;
  logic             nxt_mark, nxt_pend;

  assign last_clk  = (cnt == CNT_W'(CLKS_PER_BIT - 1));
  assign frame_end = last_clk && (idx == IDX_W'(FRAME_BITS - 1));
  assign load      = enable && (!active || frame_end);
  assign use_sync  = pend || sync_req;
  assign new_frame = make_frame(use_sync ? 8'h00 : rand_byte);
  assign rand_step = load && !use_sync;

  always_comb begin
    nxt_active = active;
    nxt_cnt    = cnt;
    nxt_idx    = idx;
    nxt_shreg  = shreg;
    nxt_bit    = bit_q;
    nxt_mark   = 1'b0;
    nxt_pend   = pend || sync_req;
    if (!enable) begin
      nxt_active = 1'b0;
      nxt_cnt    = '0;
      nxt_idx    = '0;
      nxt_bit    = 1'b0;
    end else if (load) begin
      nxt_active = 1'b1;
      nxt_cnt    = '0;
      nxt_idx    = '0;
      nxt_shreg  = new_frame;
      nxt_bit    = new_frame[0];
      nxt_mark   = 1'b1;
      nxt_pend   = 1'b0;
    end else if (last_clk) begin
      nxt_cnt    = '0;
      nxt_idx    = idx + 1'b1;
      nxt_shreg  = shreg >> 1;
      nxt_bit    = shreg[1];
      nxt_mark   = 1'b1;
    end else begin
      nxt_cnt    = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      bit_q  <= 1'b0;
      mark_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      active <= nxt_active;
      cnt    <= nxt_cnt;
      idx    <= nxt_idx;
      shreg  <= nxt_shreg;
      bit_q  <= nxt_bit;
      mark_q <= nxt_mark;
      pend   <= nxt_pend;
    end
  end
endmodule

// File: rtl/ask_carrier_gate.sv
module ask_carrier_gate #(
  parameter int HALF_DIV = 1,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nxt_active,
  input  logic             nxt_bit,
  input  logic [CNT_W-1:0] nxt_cnt,
  output logic             carrier_q
);
  logic phase_hi;

  generate
    if (HALF_DIV == 1) begin : g_direct
      assign phase_hi = ~nxt_cnt[0];
    end else begin : g_divided
      logic [CNT_W-1:0] half_idx;
      assign half_idx = nxt_cnt / CNT_W'(HALF_DIV);
      assign phase_hi = ~half_idx[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) carrier_q <= 1'b0;
    else     carrier_q <= nxt_active && nxt_bit && phase_hi;
  end
endmodule

// File: rtl/ask_frame_tx.sv
module ask_frame_tx #(
  parameter logic [15:0] SEED         = 16'hACE1,
  parameter int          HALF_DIV     = 1,
  parameter int          CARR_PER_BIT = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sync_req,
  output logic carrier_out,
  output logic bit_out,
  output logic bit_mark
);
  localparam int CLKS_PER_BIT = 2 * HALF_DIV * CARR_PER_BIT;
  localparam int CNT_W        = $clog2(CLKS_PER_BIT);

  logic [7:0]       rand_byte;
  logic             rand_step, nxt_active, nxt_bit;
  logic [CNT_W-1:0] nxt_cnt;

  ask_prbs #(.WIDTH(16), .SEED(SEED), .TAPS(16'hB400)) u_prbs (
    .clk(clk), .rst(rst), .step(rand_step), .byte_o(rand_byte)
  );

  ask_frame_seq #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .sync_req(sync_req),
    .rand_byte(rand_byte), .rand_step(rand_step),
    .nxt_active(nxt_active), .nxt_bit(nxt_bit), .nxt_cnt(nxt_cnt),
    .bit_q(bit_out), .mark_q(bit_mark)
  );

  ask_carrier_gate #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) u_carr (
    .clk(clk), .rst(rst), .nxt_active(nxt_active), .nxt_bit(nxt_bit),
    .nxt_cnt(nxt_cnt), .carrier_q(carrier_out)
  );
endmodule

// File: rtl/ask_frame_tx_chk.sv
module ask_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic carrier_out,
  input logic bit_out,
  input logic bit_mark
);
  assert_carrier_gated_R6: assert property (@(posedge clk) disable iff (rst)
    carrier_out |-> bit_out);

  assert_idle_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!bit_out && !carrier_out && !bit_mark));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |=> (bit_mark && bit_out));

  assert_single_mark_R5: assert property (@(posedge clk) disable iff (rst)
    bit_mark |=> !bit_mark);

  assert_bit_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (!bit_mark && $past(enable)) |-> $stable(bit_out));
endmodule

bind ask_frame_tx ask_frame_tx_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .carrier_out(carrier_out),
  .bit_out(bit_out), .bit_mark(bit_mark)
);

// File: tb/sim_ask_frame_tx.sv
`timescale 1ns/1ps
module sim_ask_frame_tx;
  localparam int HD  = 1;
  localparam int CPC = 40;
  localparam int CPB = 2 * HD * CPC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic sync_req = 1'b0;
  logic carrier_out, bit_out, bit_mark;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model = 16'hACE1;

  always #4 clk = ~clk;

  ask_frame_tx u0 (
    .clk(clk), .rst(rst), .enable(enable), .sync_req(sync_req),
    .carrier_out(carrier_out), .bit_out(bit_out), .bit_mark(bit_mark)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  function automatic logic [11:0] exp_frame(input logic [7:0] p);
    logic [11:0] f;
    logic par = 1'b0;
    f[0] = 1'b1; f[1] = 1'b1;
    for (int j = 0; j < 8; j++) begin f[2+j] = p[j]; par ^= p[j]; end
    f[10] = par; f[11] = 1'b0;
    return f;
  endfunction

  function automatic logic [7:0] take_random();
    logic [7:0] p = model[7:0];
    model = lfsr_step(model);
    return p;
  endfunction

  // Reads one full frame from the current negedge; optional sync pulse in bit sync_bit.
  task automatic read_frame(input logic [7:0] pay, input bit contiguous,
                            input int sync_bit, input string tag);
    logic [11:0] got = '0;
    int carr_err = 0, mark_err = 0, chg_err = 0, waited = 0;
    for (int i = 0; i < 12; i++) begin
      while (!bit_mark && waited < 4 * CPB) begin @(negedge clk); waited++; end
      if (i == 0) begin
        check(!(contiguous && waited != 0), "R9", {tag, " gap before frame"}, waited, 0);
      end
      got[i] = bit_out;
      for (int k = 0; k < CPB; k++) begin
        if (k > 0 && bit_mark) mark_err++;
        if (bit_out != got[i]) chg_err++;
        if (carrier_out != (got[i] && (((k / HD) % 2) == 0))) carr_err++;
        if (i == sync_bit && k == 3) sync_req = 1'b1;
        if (k == 4) sync_req = 1'b0;
        @(negedge clk);
      end
      waited = 0;
    end
    check(got == exp_frame(pay), "R2 R3 R4 R7", {tag, " frame bits"},
          int'(got), int'(exp_frame(pay)));
    check(carr_err == 0, "R6", {tag, " carrier pattern errors"}, carr_err, 0);
    check(mark_err == 0 && chg_err == 0, "R5", {tag, " bit timing errors"},
          mark_err + chg_err, 0);
  endtask

  task automatic t_reset();
    int bad = 0;
    repeat (3) begin
      @(negedge clk);
      if (bit_out || carrier_out || bit_mark) bad++;
    end
    rst = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (bit_out || carrier_out || bit_mark) bad++;
    end
    check(bad == 0, "R1", "outputs nonzero in reset or before enable", bad, 0);
  endtask

  task automatic t_random_run();
    enable = 1'b1;
    @(negedge clk);
    check(bit_mark && bit_out, "R8", "frame start one clock after enable",
          {bit_mark, bit_out}, 2'b11);
    read_frame(take_random(), 1'b0, -1, "rand0");
    read_frame(take_random(), 1'b1, -1, "rand1");
    read_frame(take_random(), 1'b1, -1, "rand2");
  endtask

  task automatic t_sync_midframe();
    logic [7:0] p = take_random();
    read_frame(p, 1'b1, 5, "sync-current");      // R7: current frame unchanged
    read_frame(8'h00, 1'b1, -1, "sync-frame");   // R7: zero payload next
    read_frame(take_random(), 1'b1, -1, "after-sync");
  endtask

  task automatic t_enable_drop();
    int bad = 0;
    void'(take_random());                        // frame about to be abandoned
    repeat (3 * CPB + 17) @(negedge clk);
    enable = 1'b0;
    repeat (CPB + 5) begin
      @(negedge clk);
      if (bit_out || carrier_out || bit_mark) bad++;
    end
    check(bad == 0, "R8", "outputs active while disabled", bad, 0);
    sync_req = 1'b1;                             // R7: request while idle
    @(negedge clk);
    sync_req = 1'b0;
    repeat (10) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(bit_mark && bit_out, "R8", "restart after re-enable",
          {bit_mark, bit_out}, 2'b11);
    read_frame(8'h00, 1'b0, -1, "idle-sync");
    read_frame(take_random(), 1'b1, -1, "post-abort");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_random_run();
    t_sync_midframe();
    t_enable_drop();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end
endmodule